// File: doc/BRIEF.md
# Supply-Loss Bus Lockout Sequencer

This block sits between a byte-wide asynchronous-SRAM-style host bus and the memory core behind it. It turns two chip enables, an output enable and a write enable into a core write strobe and a data-bus drive enable. It also watches two supply comparator flags. One says the supply has dropped below the power-fail trip level. The other says the supply has dropped below the level at which the backup cell must take over.

When the trip flag appears, the block pulls its active-low interrupt at once. If the trip lasts for a programmable number of clock cycles, it locks the bus: writes are refused, the data bus is not driven, and every host input is ignored. When the trip clears, the interrupt is released straight away. The lock is kept for a further programmable recovery interval, and only then is normal access allowed again. A trip that clears before the lock engages cancels the sequence. The backup-cell select follows the switchover flag in both directions.

Both comparator flags are asynchronous and pass through two-flop synchronisers. All delays are counted in system clock cycles. The analog comparators and the power switch itself lie outside the block.

Top module: `pwrfail_gate`

## Requirements
- R1: The core is selected only while `ce1_n`=0 and `ce2`=1. With either enable inactive, `mem_we` and `dq_oe` are both 0.
- R2: While selected and unlocked, `we_n`=0 gives `mem_we`=1. `dq_oe`=1 only when `oe_n`=0 and `we_n`=1, so a low `we_n` turns off the data drive even when `oe_n` is low.
- R3: When `trip_async` rises, `int_n` stays high after the first two clock edges and goes low after the third edge: two synchroniser stages plus the sequencer register.
- R4: If the trip persists, `wr_lock` rises exactly `DESEL_CYC` clock edges after the edge that pulled `int_n` low, and not one edge earlier.
- R5: While `wr_lock`=1, `mem_we` and `dq_oe` stay 0 whatever the bus inputs are.
- R6: `bat_sel` copies `swov_async` two clock edges later, both when the flag rises and when it falls.
- R7: When the trip clears during lockout, `int_n` returns high after the third edge. `wr_lock` then stays high for exactly `RECOV_CYC` further edges before access is honoured.
- R8: A trip that clears before the deselect delay ends releases `int_n` (three edges after the clear), and `wr_lock` never rises.
- R9: A write that is active when the lock engages is cut off: `mem_we` falls in the same cycle that `wr_lock` rises.
- R10: A new trip during the recovery interval returns the block to lockout with `int_n` low. After that trip clears, the full `RECOV_CYC` interval starts again.
- R11: Reset leaves `int_n`=1, `wr_lock`=1 and `bat_sel`=0. After reset is released, a full `RECOV_CYC` lockout runs before access is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce1_n | input | 1 | Host chip enable, active low |
| ce2 | input | 1 | Host chip enable, active high |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| trip_async | input | 1 | Comparator flag: supply below power-fail trip level (asynchronous) |
| swov_async | input | 1 | Comparator flag: supply below backup switchover level (asynchronous) |
| int_n | output | 1 | Power-fail interrupt, active low |
| wr_lock | output | 1 | Deselect and write-protect gate, 1 = bus locked |
| mem_we | output | 1 | Write strobe to the memory core |
| dq_oe | output | 1 | Drive enable for the data bus |
| bat_sel | output | 1 | Selects the backup cell as supply |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the lock engaging and a host write in progress. The bench holds a write open across a persistent trip, then checks that `mem_we` is still high one cycle before `wr_lock` rises and is low in the very cycle it rises. The second pair is a new trip and the end of recovery. The bench trips again part-way through the recovery interval, then checks that the interrupt falls and that, once the trip clears, the lock lasts the full recovery count from the new release.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    PF_RUN  = 2'd0,  // supply good, bus honoured
    PF_WARN = 2'd1,  // trip seen, interrupt low, deselect delay running
    PF_OFF  = 2'd2,  // bus locked, interrupt low
    PF_HOLD = 2'd3   // supply back, interrupt released, recovery lockout
  } pf_state_e;

  // Bit positions of the comparator flags inside the synchroniser vector
  localparam int FLAG_TRIP = 0;
  localparam int FLAG_SWOV = 1;
  localparam int N_FLAGS   = 2;

  // Both enables in their active state
  function automatic logic chip_sel(input logic ce1_n, input logic ce2);
    return !ce1_n && ce2;
  endfunction

  // True on the last cycle of an interval lasting lim cycles
  function automatic logic cnt_done(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_async[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfseq_pkg::*;
#(
  parameter int DESEL_CYC = 4000,
  parameter int RECOV_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,     // synchronised below-trip flag
  output logic int_n,
  output logic lock
);

  localparam int MAXC  = max2(DESEL_CYC, RECOV_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  pf_state_e        state, nxt;
  logic [CNT_W-1:0] cnt;

  // Named internal events
  logic ev_trip_seen, ev_cancel, ev_desel, ev_restore, ev_retrip, ev_resume;
  assign ev_trip_seen = (state == PF_RUN)  && trip;
  assign ev_cancel    = (state == PF_WARN) && !trip;
  assign ev_desel     = (state == PF_WARN) && trip && cnt_done(32'(cnt), DESEL_CYC);
  assign ev_restore   = (state == PF_OFF)  && !trip;
  assign ev_retrip    = (state == PF_HOLD) && trip;
  assign ev_resume    = (state == PF_HOLD) && !trip && cnt_done(32'(cnt), RECOV_CYC);

  always_comb begin
    nxt = state;
    unique case (state)
      PF_RUN:  if (ev_trip_seen) nxt = PF_WARN;
      PF_WARN: if (ev_cancel) nxt = PF_RUN; else if (ev_desel) nxt = PF_OFF;
      PF_OFF:  if (ev_restore) nxt = PF_HOLD;
      PF_HOLD: if (ev_retrip) nxt = PF_OFF; else if (ev_resume) nxt = PF_RUN;
      default: nxt = PF_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PF_HOLD;          // power-up behaves as a supply return
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || state == PF_RUN || state == PF_OFF) cnt <= '0;
      else                                                     cnt <= cnt + 1'b1;
    end
  end

  assign int_n = !((state == PF_WARN) || (state == PF_OFF));
  assign lock  = (state == PF_OFF) || (state == PF_HOLD);

  // Checker counter: consecutive cycles of lock with interrupt released
  logic [CNT_W:0] hold_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_age <= '0;
    else if (lock && int_n)  hold_age <= hold_age + 1'b1;
    else                     hold_age <= '0;
  end

  // R3: a synchronised trip in normal operation pulls the interrupt next edge
  p_int_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PF_RUN && trip) |=> !int_n);

  // R4: the lock only engages out of the warning phase with the interrupt low
  p_lock_after_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (!int_n && $past(state) == PF_WARN));

  // R7: the lock falls only after a full recovery interval
  p_recov_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> (32'(hold_age) == RECOV_CYC));

  // R8: a trip clearing during the warning phase releases without locking
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PF_WARN && !trip) |=> (int_n && !lock));

  // R10: a trip during recovery drops straight back to lockout
  p_retrip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PF_HOLD && trip) |=> (!int_n && lock));

endmodule

// File: rtl/pfs_bus.sv
module pfs_bus
  import pfseq_pkg::*;
(
  input  logic ce1_n,
  input  logic ce2,
  input  logic oe_n,
  input  logic we_n,
  input  logic lock,
  output logic mem_we,
  output logic dq_oe
);

  logic sel;
  assign sel    = chip_sel(ce1_n, ce2) && !lock;
  assign mem_we = sel && !we_n;
  assign dq_oe  = sel && we_n && !oe_n;

endmodule

// File: rtl/pwrfail_gate.sv
module pwrfail_gate
  import pfseq_pkg::*;
#(
  parameter int DESEL_CYC = 4000,
  parameter int RECOV_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic oe_n,
  input  logic we_n,
  input  logic trip_async,
  input  logic swov_async,
  output logic int_n,
  output logic wr_lock,
  output logic mem_we,
  output logic dq_oe,
  output logic bat_sel
);

  logic [N_FLAGS-1:0] raw_flags, sync_flags;
  assign raw_flags[FLAG_TRIP] = trip_async;
  assign raw_flags[FLAG_SWOV] = swov_async;

  pfs_sync #(.W(N_FLAGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_flags),
    .q       (sync_flags)
  );

  pfs_seq #(.DESEL_CYC(DESEL_CYC), .RECOV_CYC(RECOV_CYC)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .trip  (sync_flags[FLAG_TRIP]),
    .int_n (int_n),
    .lock  (wr_lock)
  );

  pfs_bus u_bus (
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .lock   (wr_lock),
    .mem_we (mem_we),
    .dq_oe  (dq_oe)
  );

  assign bat_sel = sync_flags[FLAG_SWOV];

  // R2: never strobe a write and drive the bus together
  p_we_oe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && dq_oe));

  // R5: a locked bus is silent
  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |-> (!mem_we && !dq_oe));

  // R6: backup select follows the switchover flag two edges later
  p_bat_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_sel) |-> $past(swov_async, 2));
  p_bat_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bat_sel) |-> !$past(swov_async, 2));

  // R9: a write in flight ends in the cycle the lock engages
  p_write_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we) && $rose(wr_lock)) |-> !mem_we);

endmodule

// File: tb/pwrfail_gate_bench.sv
`timescale 1ns/1ps
module pwrfail_gate_bench;
  localparam int DCY = 8;
  localparam int RCY = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic trip = 1'b0, swov = 1'b0;
  logic int_n, wr_lock, mem_we, dq_oe, bat_sel;

  pwrfail_gate #(.DESEL_CYC(DCY), .RECOV_CYC(RCY)) u_pwrfail_gate (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .trip_async(trip), .swov_async(swov),
    .int_n(int_n), .wr_lock(wr_lock), .mem_we(mem_we), .dq_oe(dq_oe), .bat_sel(bat_sel)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard item: vector {int_n, wr_lock, mem_we, dq_oe, bat_sel} due after edge 'at'
  typedef struct {
    int         at;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic expect_at(input int at, input logic [4:0] v, input string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_bus(input logic a, input logic b, input logic c, input logic d);
    ce1_n = a; ce2 = b; oe_n = c; we_n = d;
  endtask

  // Monitor: compares due items shortly after each edge
  always begin
    @(posedge clk);
    #1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      logic [4:0] obs;
      e = q.pop_front();
      obs = {int_n, wr_lock, mem_we, dq_oe, bat_sel};
      checks++;
      if (obs !== e.v) begin
        fails++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b", e.tag, cyc, obs, e.v);
      end
    end
  end

  initial begin
    int c, c2;
    // R11 reset state
    @(negedge clk);
    expect_at(cyc + 1, 5'b11000, "R11 reset");
    tick(2);
    rst_n = 1'b1;
    c = cyc;
    expect_at(c + RCY - 1, 5'b11000, "R11 lockout");
    expect_at(c + RCY,     5'b10000, "R11 release");
    tick(RCY + 1);

    // R1 / R2 decode
    set_bus(1'b0, 1'b1, 1'b0, 1'b1); expect_at(cyc + 1, 5'b10010, "R2 read");           tick(1);
    set_bus(1'b0, 1'b1, 1'b0, 1'b0); expect_at(cyc + 1, 5'b10100, "R2 write over oe");  tick(1);
    set_bus(1'b0, 1'b0, 1'b0, 1'b0); expect_at(cyc + 1, 5'b10000, "R1 ce2 low");        tick(1);
    set_bus(1'b1, 1'b1, 1'b0, 1'b0); expect_at(cyc + 1, 5'b10000, "R1 ce1 high");       tick(1);
    set_bus(1'b1, 1'b0, 1'b1, 1'b1);

    // R3 / R8 short trip cancelled
    trip = 1'b1; c = cyc;
    expect_at(c + 2, 5'b10000, "R3 before sync");
    expect_at(c + 3, 5'b00000, "R3 int low");
    tick(4);
    trip = 1'b0; c2 = cyc;
    expect_at(c2 + 2, 5'b00000, "R8 still warning");
    expect_at(c2 + 3, 5'b10000, "R8 cancel");
    expect_at(c + 3 + DCY, 5'b10000, "R8 no lock");
    tick(DCY + 2);

    // R4 / R9 persistent trip with write in flight
    set_bus(1'b0, 1'b1, 1'b1, 1'b0);
    trip = 1'b1; c = cyc;
    expect_at(c + 1, 5'b10100, "R9 write active");
    expect_at(c + 3, 5'b00100, "R3 int low during write");
    expect_at(c + 3 + DCY - 1, 5'b00100, "R4 not yet locked");
    expect_at(c + 3 + DCY, 5'b01000, "R4 locked");
    expect_at(c + 3 + DCY, 5'b01000, "R9 write cut");
    tick(DCY + 4);

    // R5 bus ignored while locked
    set_bus(1'b0, 1'b1, 1'b0, 1'b1); expect_at(cyc + 1, 5'b01000, "R5 read blocked");  tick(1);
    set_bus(1'b0, 1'b1, 1'b0, 1'b0); expect_at(cyc + 1, 5'b01000, "R5 write blocked"); tick(1);

    // R6 backup select
    swov = 1'b1; c = cyc;
    expect_at(c + 1, 5'b01000, "R6 not yet on");
    expect_at(c + 2, 5'b01001, "R6 on");
    tick(3);
    swov = 1'b0; c = cyc;
    expect_at(c + 1, 5'b01001, "R6 not yet off");
    expect_at(c + 2, 5'b01000, "R6 off");
    tick(3);

    // R7 recovery
    set_bus(1'b0, 1'b1, 1'b0, 1'b1);
    trip = 1'b0; c = cyc;
    expect_at(c + 2, 5'b01000, "R7 int held");
    expect_at(c + 3, 5'b11000, "R7 int released");
    expect_at(c + 3 + RCY - 1, 5'b11000, "R7 still locked");
    expect_at(c + 3 + RCY, 5'b10010, "R7 access");
    tick(RCY + 5);

    // R10 re-trip during recovery
    trip = 1'b1;
    tick(DCY + 6);
    trip = 1'b0;
    tick(6);
    trip = 1'b1; c = cyc;
    expect_at(c + 3, 5'b01000, "R10 back to lockout");
    tick(5);
    trip = 1'b0; c = cyc;
    expect_at(c + 3, 5'b11000, "R10 int released");
    expect_at(c + 3 + RCY - 1, 5'b11000, "R10 full restart");
    expect_at(c + 3 + RCY, 5'b10010, "R10 access");
    tick(RCY + 5);

    while (q.size() > 0) tick(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule